// File: doc/BRIEF.md
# Exhaustive PLL Divider Search Engine

This block picks the reference divider M and the feedback divider N of a clock synthesizer so that the synthesized frequency lands as close as possible to a requested value. The request arrives in units of 10 kHz on `req` together with a one-cycle `start` pulse. A zero request is a special case that returns a fixed code word at once. Any other request is first limited to a legal window. From the limited value the block forms a scaled target and a post-divider exponent k. It then tries every (M, N) pair in turn and keeps the pair with the smallest absolute frequency error.

Each candidate frequency comes from a fixed-point model of the synthesizer with eight fractional bits. A shared iterative divider evaluates one candidate per division. At the end the block packs N, k and M into a 16-bit code word, drops `busy` and pulses `done`. The code word stays on `word` until the next search completes. The bus sequence that writes this word into the clock chip lies outside this block.

Top module: `pll_mn_search`

## Requirements
- R1: A start with `req` equal to 0 sets `word` to 16'h00E0 and pulses `done` in the cycle after the start. No search runs and `busy` stays low.
- R2: A nonzero request below 8000 behaves exactly like a request of 8000.
- R3: A request above 15938 behaves exactly like a request of 15938.
- R4: The target is floor(clamped × 256 / 100). It is computed from the clamped request before any doubling.
- R5: k is the number of doublings of the clamped request needed to reach at least 64000. For every legal clamped value this gives k = 3, so bits 7:6 of a nonzero result are 2'b11.
- R6: The candidate frequency of a pair is floor(938356 × (N+8) / (2^k × 256 × (M+2))). Its error is the absolute difference from the target.
- R7: M runs from 2 to 30 in the outer loop and N runs from 35 to 247 in the inner loop. A pair replaces the kept best only when its error is strictly smaller, so the first pair that reaches the minimum error wins.
- R8: The result word equals (N << 8) + (k << 6) + M. N sits in bits 15:8, k in bits 7:6 and M in bits 5:0.
- R9: `busy` rises in the cycle after a nonzero start is accepted and stays high until the cycle in which `done` pulses for one cycle. A `start` seen while `busy` is high is ignored. `word` does not change while `busy` is high.
- R10: After reset `busy` and `done` are low and `word` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search; accepted only while idle |
| req | input | 16 | Requested frequency in units of 10 kHz, sampled with `start` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when `word` has been updated |
| word | output | 16 | Packed divider code word |

## Verification
The hardest behaviour to reach is the tie rule. Several (M, N) pairs can give the same error, and only the earliest one in the search order may win. That earliest pair can only be seen in the final word after a full sweep of more than six thousand candidates. The bench runs full sweeps for a low-clamped request, a mid-range request and a high-clamped request. Each result is compared against a brute-force model written from the requirements, which applies the same strict-less-than rule, so a design that moves to a later pair on a tie disagrees on the word. A zero-valued start is injected in the middle of a sweep to show that it is ignored while busy.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  // 14.31818 MHz reference scaled by 65536
  localparam int unsigned REF_SCALED = 938356;
  // Fractional bits of the frequency model
  localparam int FRAC_SHIFT = 8;
  // Code word returned for a zero request
  localparam logic [15:0] ZERO_WORD = 16'h00E0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } srch_state_t;
endpackage

// File: rtl/pll_req_prep.sv
module pll_req_prep #(
  parameter int REQ_W = 16,
  parameter int F_LO  = 8000,
  parameter int F_HI  = 15938,
  parameter int KW    = 2,
  parameter int TW    = 16
) (
  input  logic [REQ_W-1:0] req,
  output logic [TW-1:0]    tgt,
  output logic [KW-1:0]    k
);
  localparam int unsigned K_THRESH = F_LO * 8;

  logic [31:0] clamped;
  logic        found;

  // Limit the request to the legal window
  always_comb begin
    clamped = 32'(req);
    if (clamped < 32'(F_LO)) clamped = 32'(F_LO);
    if (clamped > 32'(F_HI)) clamped = 32'(F_HI);
  end

  // Scaled target is taken before any doubling
  assign tgt = TW'((clamped * 32'd256) / 32'd100);

  // Count the doublings needed to reach the threshold
  always_comb begin
    k     = '0;
    found = 1'b0;
    for (int j = 0; j < (1 << KW); j++) begin
      if (!found && ((clamped << j) >= K_THRESH)) begin
        k     = KW'(j);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_div_unit.sv
module pll_div_unit #(
  parameter int DW = 20,
  parameter int VW = 6,
  parameter int RB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);
  localparam int STEPS = (DW + RB - 1) / RB;
  localparam int PW    = STEPS * RB;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int XW    = DW + VW;

  logic [PW-1:0] acc_q, acc_d, a_t;
  logic [VW:0]   rem_q, rem_d, r_t, sh;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [DW-1:0] dvd_q, dvd_d;
  logic [VW-1:0] dvs_q, dvs_d;
  logic          ge;

  // RB restoring steps per cycle
  always_comb begin
    r_t = rem_q;
    a_t = acc_q;
    sh  = '0;
    ge  = 1'b0;
    for (int i = 0; i < RB; i++) begin
      sh  = {r_t[VW-1:0], a_t[PW-1]};
      ge  = (sh >= {1'b0, dvs_q});
      r_t = ge ? (sh - {1'b0, dvs_q}) : sh;
      a_t = {a_t[PW-2:0], ge};
    end
  end

  always_comb begin
    acc_d  = acc_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    dvs_d  = dvs_q;
    done_d = 1'b0;
    if (go) begin
      acc_d = PW'(dividend);
      rem_d = '0;
      cnt_d = CW'(STEPS);
      dvd_d = dividend;
      dvs_d = divisor;
    end else if (cnt_q != '0) begin
      acc_d  = a_t;
      rem_d  = r_t;
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      dvd_q  <= dvd_d;
      dvs_q  <= dvs_d;
    end
  end

  assign quotient = acc_q[DW-1:0];
  assign done     = done_q;

  // R6: the quotient handed out is the exact floor of the captured operands
  logic [XW-1:0] chk_prod;
  assign chk_prod = XW'(quotient) * XW'(dvs_q);

  a_r6_quotient_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_prod <= XW'(dvd_q)) && ((XW'(dvd_q) - chk_prod) < XW'(dvs_q)));
endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
  import pll_search_pkg::*;
#(
  parameter int REQ_W = 16,
  parameter int F_LO  = 8000,
  parameter int F_HI  = 15938,
  parameter int M_MIN = 2,
  parameter int M_MAX = 30,
  parameter int N_MIN = 35,
  parameter int N_MAX = 247,
  parameter int RB    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REQ_W-1:0] req,
  output logic             busy,
  output logic             done,
  output logic [15:0]      word
);
  localparam int KW     = 2;
  localparam int TW     = $clog2(F_HI * 256 / 100 + 1);
  localparam int MW     = $clog2(M_MAX + 1);
  localparam int NW     = $clog2(N_MAX + 1);
  localparam int VW     = $clog2(M_MAX + 3);
  localparam int PROD_W = $clog2(REF_SCALED * (N_MAX + 8) + 1);
  localparam int DW     = PROD_W - FRAC_SHIFT;
  localparam int T_LO   = F_LO * 256 / 100;
  localparam int T_HI   = F_HI * 256 / 100;

  srch_state_t   state_q, state_d;
  logic [TW-1:0] tgt_q, tgt_d, tgt_w;
  logic [KW-1:0] k_q, k_d, k_w;
  logic [MW-1:0] m_q, m_d, m_nx, best_m_q, best_m_d, fin_m;
  logic [NW-1:0] n_q, n_d, n_nx, best_n_q, best_n_d, fin_n;
  logic [DW-1:0] best_err_q, best_err_d, err;
  logic          launch_q, launch_d;
  logic [15:0]   word_q, word_d;
  logic          done_q, done_d;

  logic              div_go, div_done, last_pair, better;
  logic [PROD_W-1:0] prod;
  logic [DW-1:0]     div_dvd, div_quo;
  logic [VW-1:0]     div_dvs;

  pll_req_prep #(
    .REQ_W(REQ_W), .F_LO(F_LO), .F_HI(F_HI), .KW(KW), .TW(TW)
  ) u_prep (
    .req (req),
    .tgt (tgt_w),
    .k   (k_w)
  );

  pll_div_unit #(.DW(DW), .VW(VW), .RB(RB)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .quotient (div_quo),
    .done     (div_done)
  );

  // Pair walk: N inner, M outer
  assign last_pair = (m_q == MW'(M_MAX)) && (n_q == NW'(N_MAX));

  always_comb begin
    m_nx = m_q;
    n_nx = n_q;
    if (div_done) begin
      if (n_q == NW'(N_MAX)) begin
        n_nx = NW'(N_MIN);
        m_nx = m_q + 1'b1;
      end else begin
        n_nx = n_q + 1'b1;
      end
    end
  end

  assign div_go  = (state_q == ST_RUN) && (launch_q || (div_done && !last_pair));
  assign prod    = PROD_W'(REF_SCALED) * (PROD_W'(n_nx) + PROD_W'(8));
  assign div_dvd = DW'(prod >> (PROD_W'(k_q) + PROD_W'(FRAC_SHIFT)));
  assign div_dvs = VW'(m_nx) + VW'(2);

  // Absolute error and strict improvement test
  assign err    = (div_quo >= DW'(tgt_q)) ? (div_quo - DW'(tgt_q)) : (DW'(tgt_q) - div_quo);
  assign better = div_done && (err < best_err_q);
  assign fin_m  = better ? m_q : best_m_q;
  assign fin_n  = better ? n_q : best_n_q;

  always_comb begin
    state_d    = state_q;
    tgt_d      = tgt_q;
    k_d        = k_q;
    m_d        = m_q;
    n_d        = n_q;
    best_err_d = best_err_q;
    best_m_d   = best_m_q;
    best_n_d   = best_n_q;
    launch_d   = 1'b0;
    word_d     = word_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (req == '0) begin
            word_d = ZERO_WORD;
            done_d = 1'b1;
          end else begin
            state_d    = ST_RUN;
            tgt_d      = tgt_w;
            k_d        = k_w;
            m_d        = MW'(M_MIN);
            n_d        = NW'(N_MIN);
            best_err_d = '1;
            launch_d   = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (better) begin
          best_err_d = err;
          best_m_d   = m_q;
          best_n_d   = n_q;
        end
        if (div_done) begin
          m_d = m_nx;
          n_d = n_nx;
          if (last_pair) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            word_d  = (16'(fin_n) << 8) + (16'(k_q) << 6) + 16'(fin_m);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tgt_q      <= '0;
      k_q        <= '0;
      m_q        <= '0;
      n_q        <= '0;
      best_err_q <= '1;
      best_m_q   <= '0;
      best_n_q   <= '0;
      launch_q   <= 1'b0;
      word_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      tgt_q      <= tgt_d;
      k_q        <= k_d;
      m_q        <= m_d;
      n_q        <= n_d;
      best_err_q <= best_err_d;
      best_m_q   <= best_m_d;
      best_n_q   <= best_n_d;
      launch_q   <= launch_d;
      word_q     <= word_d;
      done_q     <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
  assign word = word_q;

  a_r1_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (req == '0)) |=> (done && (word == ZERO_WORD)));

  a_r1_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (req == '0)) |=> !busy);

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(word));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && $past(state_q == ST_RUN)) |-> (best_err_q <= $past(best_err_q)));

  a_r4_target_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((tgt_q >= TW'(T_LO)) && (tgt_q <= TW'(T_HI))));
endmodule

// File: tb/tb_pll_mn_search.sv
module tb_pll_mn_search;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] req;
  logic        busy;
  logic        done;
  logic [15:0] word;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  pll_mn_search dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .req   (req),
    .busy  (busy),
    .done  (done),
    .word  (word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Brute-force model written from the requirements
  function automatic logic [15:0] model(input int unsigned r);
    longint c, tgt, f, fo, diff, best;
    int k, bm, bn;
    if (r == 0) return 16'h00E0;
    c = r;
    if (c < 8000) c = 8000;
    if (c > 15938) c = 15938;
    tgt = c * 256 / 100;
    k = 0;
    f = c;
    while (f < 64000) begin
      f = f * 2;
      k++;
    end
    best = 64'h7FFF_FFFF_FFFF_FFFF;
    bm = 0;
    bn = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        fo = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        diff = (fo > tgt) ? fo - tgt : tgt - fo;
        if (diff < best) begin
          best = diff;
          bm = m;
          bn = n;
        end
      end
    end
    return 16'((bn << 8) + (k << 6) + bm);
  endfunction

  task automatic check(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Driver: pushes the expected word and pulses start
  task automatic issue(input logic [15:0] r, input logic [15:0] exp, input string tg);
    exp_q.push_back(exp);
    tag_q.push_back(tg);
    @(negedge clk);
    req   = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 40000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  // Monitor: pops and compares on every completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", word, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(word == e, t, word, e);
      end
    end
  end

  // Monitor: word must not move while busy (R9)
  logic [15:0] prev_word;
  logic        prev_busy;
  always @(negedge clk) begin
    if (rst_n && prev_busy && busy)
      if (word != prev_word) check(1'b0, "R9 word moved while busy", word, prev_word);
    prev_word = word;
    prev_busy = busy;
  end

  initial begin
    #(1900000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", word, 16'h0000);
    report();
  end

  initial begin
    logic [15:0] e_lo, e_mid, e_hi, hold;
    start = 1'b0;
    req   = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy after reset", 16'(busy), 16'h0);
    check(done == 1'b0, "R10 done after reset", 16'(done), 16'h0);
    check(word == 16'h0, "R10 word after reset", word, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero request, no search
    issue(16'd0, 16'h00E0, "R1 zero request word");
    check(done == 1'b1, "R1 done one cycle after start", 16'(done), 16'h1);
    check(busy == 1'b0, "R1 busy stays low", 16'(busy), 16'h0);
    @(negedge clk);
    check(done == 1'b0, "R9 done is one cycle", 16'(done), 16'h0);

    e_lo  = model(8000);
    e_mid = model(12345);
    e_hi  = model(15938);

    // R2: below-window request equals the floor value
    check(model(5000) == e_lo, "R2 model clamp low", model(5000), e_lo);
    issue(16'd5000, e_lo, "R2 R4 R6 R7 low clamp word");
    check(busy == 1'b1, "R9 busy after accept", 16'(busy), 16'h1);
    wait_done();
    check(word[7:6] == 2'b11, "R5 k field", 16'(word[7:6]), 16'h3);
    check(word[5:0] >= 6'd2 && word[5:0] <= 6'd30, "R8 M field range", 16'(word[5:0]), 16'd2);
    check(word[15:8] >= 8'd35 && word[15:8] <= 8'd247, "R8 N field range", 16'(word[15:8]), 16'd35);
    @(negedge clk);
    check(busy == 1'b0, "R9 idle after done", 16'(busy), 16'h0);

    // R9: start during a search is ignored
    issue(16'd12345, e_mid, "R6 R7 R8 mid request word");
    hold = word;
    repeat (100) @(negedge clk);
    req   = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R9 start ignored while busy", {14'b0, busy, done}, 16'h2);
    check(word == hold, "R9 word unchanged by ignored start", word, hold);
    wait_done();
    @(negedge clk);

    // R3: above-window request equals the ceiling value
    issue(16'hFFFF, e_hi, "R3 R5 R7 high clamp word");
    wait_done();
    check(word[7:6] == 2'b11, "R5 k field high", 16'(word[7:6]), 16'h3);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 every start answered once", 16'(exp_q.size()), 16'h0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule